// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block turns a free-running oscillator clock into two clock enables, one for the CPU and one for the peripherals. It chooses among six power modes: full-rate run, divided-rate slow, wait, slow-wait, halt with the oscillator kept alive (active-halt), and full halt. Downstream logic stays on the oscillator clock and only advances in cycles where its enable is high. No derived clock is ever generated.

Software sets two configuration fields through a single-cycle write strobe. One field turns slow mode on or off. The other picks the divide ratio. The CPU asks for wait or halt with one-cycle request pulses. An option input tells a halt request whether the oscillator stays up. Interrupt and wakeup-timer inputs bring the block back out of the low-power modes, and a synchronous reset always returns it to run. The current mode is visible on a three-bit output.

Top module: `clkpm_ctrl`

## Requirements
- R1: Synchronous reset puts the block in run mode (mode code 0). In run mode, both clock enables are high in every cycle.
- R2: A cycle with `cfg_we` high captures `cfg_slow_en` and `cfg_div_sel`. In the following cycle, run mode moves to slow mode (code 1) if the captured enable is 1, and slow mode moves back to run if it is 0. A select value k gives a divide ratio of 2^(k+1): 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16. After reset the select is 0.
- R3: In slow mode, `cpu_ce` and `per_ce` are identical. They pulse high for one cycle once every ratio cycles.
- R4: A wait request in slow mode enters slow-wait (code 3). There `cpu_ce` stays low and `per_ce` keeps pulsing at the divided rate.
- R5: A wait request in run mode enters wait (code 2). There `cpu_ce` is low and `per_ce` is high every cycle.
- R6: A halt request in run or slow mode enters active-halt (code 4) when `osc_keep` is 1, and full halt (code 5) when it is 0. Both enables are low in either halt mode. A halt request wins over a wait request made in the same cycle.
- R7: Full halt is left only through `irq_wake` or reset, and both go to run mode. `tick_wake` has no effect in full halt.
- R8: Active-halt returns to run mode on either `irq_wake` or `tick_wake`.
- R9: `irq_wake` returns wait to run mode and returns slow-wait to slow mode.
- R10: A new divide select takes effect only when the current divided period ends. The period in progress keeps the old length.
- R11: Wait and halt requests have no effect while the block is in wait, slow-wait, active-halt or halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slow_en | input | 1 | Slow mode enable to store |
| cfg_div_sel | input | 2 | Divide select to store |
| wait_req | input | 1 | Wait request pulse from the CPU |
| halt_req | input | 1 | Halt request pulse from the CPU |
| osc_keep | input | 1 | Keep the oscillator running through halt |
| irq_wake | input | 1 | Interrupt wakeup |
| tick_wake | input | 1 | Wakeup timer tick |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| mode_o | output | 3 | Current mode code |

## Verification
The assertions assume that reset is synchronous and that each wakeup and request input is a level sampled once per cycle, so a hold property in a low-power mode only holds while the matching wake input is low. The bench drives every input on the falling edge and uses one-cycle pulses for requests and wakes. It holds `osc_keep` steady around each halt request. It performs the divide-select change in the middle of a period, so that the rollover rule is exercised with a known phase.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int SEL_W = 2;
    localparam int CNT_W = 1 << SEL_W;

    typedef enum logic [2:0] {
        PM_RUN   = 3'd0,
        PM_SLOW  = 3'd1,
        PM_WAIT  = 3'd2,
        PM_SWAIT = 3'd3,
        PM_AHALT = 3'd4,
        PM_HALT  = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic             slow_en;
        logic [SEL_W-1:0] sel;
    } pm_cfg_t;

    typedef struct packed {
        logic cpu;
        logic per;
    } pm_ce_t;

    // Terminal count of the divider for a given select: ratio 2^(sel+1) minus one.
    function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        int r;
        r = (2 << sel) - 1;
        return CNT_W'(r);
    endfunction

    function automatic logic is_active(input pm_mode_e m);
        return (m == PM_RUN) || (m == PM_SLOW);
    endfunction

    function automatic logic is_divided(input pm_mode_e m);
        return (m == PM_SLOW) || (m == PM_SWAIT);
    endfunction

endpackage

// File: rtl/clkpm_divider.sv
module clkpm_divider
    import clkpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_on,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] ratio_q;
    logic             at_last;

    assign at_last = (cnt_q == div_last(ratio_q));
    assign tick_o  = div_on && at_last;

    always_ff @(posedge clk) begin
        if (rst || !div_on) begin
            cnt_q   <= '0;
            ratio_q <= sel_i;
        end else if (at_last) begin
            cnt_q   <= '0;
            ratio_q <= sel_i;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R10
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (div_on && !at_last) |=> $stable(ratio_q));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/clkpm_fsm.sv
module clkpm_fsm
    import clkpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     slow_en,
    input  logic     wait_req,
    input  logic     halt_req,
    input  logic     osc_keep,
    input  logic     irq_wake,
    input  logic     tick_wake,
    output pm_mode_e mode_q
);

    pm_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            PM_RUN, PM_SLOW: begin
                if (halt_req)
                    mode_d = osc_keep ? PM_AHALT : PM_HALT;
                else if (wait_req)
                    mode_d = (mode_q == PM_SLOW) ? PM_SWAIT : PM_WAIT;
                else
                    mode_d = slow_en ? PM_SLOW : PM_RUN;
            end
            PM_WAIT:  if (irq_wake) mode_d = PM_RUN;
            PM_SWAIT: if (irq_wake) mode_d = PM_SLOW;
            PM_AHALT: if (irq_wake || tick_wake) mode_d = PM_RUN;
            PM_HALT:  if (irq_wake) mode_d = PM_RUN;
            default:  mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_RUN;
        else     mode_q <= mode_d;
    end

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_HALT && !irq_wake) |=> (mode_q == PM_HALT));

    // R9
    swait_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_SWAIT && irq_wake) |=> (mode_q == PM_SLOW));

    // R11
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_WAIT && !irq_wake) |=> (mode_q == PM_WAIT));

    // R6
    halt_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (is_active(mode_q) && halt_req && wait_req) |=>
            (mode_q == PM_AHALT || mode_q == PM_HALT));

    // R8
    ahalt_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_AHALT && tick_wake) |=> (mode_q == PM_RUN));

endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate
    import clkpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pm_mode_e mode,
    input  logic     slow_tick,
    output pm_ce_t   ce
);

    always_comb begin
        unique case (mode)
            PM_RUN:   ce = '{cpu: 1'b1,      per: 1'b1};
            PM_SLOW:  ce = '{cpu: slow_tick, per: slow_tick};
            PM_WAIT:  ce = '{cpu: 1'b0,      per: 1'b1};
            PM_SWAIT: ce = '{cpu: 1'b0,      per: slow_tick};
            default:  ce = '{cpu: 1'b0,      per: 1'b0};
        endcase
    end

    // R6
    halt_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_AHALT || mode == PM_HALT) |-> (!ce.cpu && !ce.per));

    // R5
    wait_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_WAIT) |-> (!ce.cpu && ce.per));

    // R3
    slow_same_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SLOW) |-> (ce.cpu == ce.per));

    // R4
    swait_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SWAIT) |-> !ce.cpu);

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_slow_en,
    input  logic [SEL_W-1:0] cfg_div_sel,
    input  logic             wait_req,
    input  logic             halt_req,
    input  logic             osc_keep,
    input  logic             irq_wake,
    input  logic             tick_wake,
    output logic             cpu_ce,
    output logic             per_ce,
    output logic [2:0]       mode_o
);

    pm_cfg_t  cfg_q;
    pm_mode_e mode;
    pm_ce_t   ce;
    logic     slow_tick;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= '{slow_en: cfg_slow_en, sel: cfg_div_sel};
    end

    clkpm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .slow_en   (cfg_q.slow_en),
        .wait_req  (wait_req),
        .halt_req  (halt_req),
        .osc_keep  (osc_keep),
        .irq_wake  (irq_wake),
        .tick_wake (tick_wake),
        .mode_q    (mode)
    );

    clkpm_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .div_on (is_divided(mode)),
        .sel_i  (cfg_q.sel),
        .tick_o (slow_tick)
    );

    clkpm_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .slow_tick (slow_tick),
        .ce        (ce)
    );

    assign cpu_ce = ce.cpu;
    assign per_ce = ce.per;
    assign mode_o = mode;

    // R1
    run_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0) |-> (cpu_ce && per_ce));

endmodule

// File: tb/clkpm_ctrl_tb_top.sv
module clkpm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_slow_en = 1'b0;
    logic [1:0] cfg_div_sel = 2'd0;
    logic       wait_req = 1'b0, halt_req = 1'b0, osc_keep = 1'b0;
    logic       irq_wake = 1'b0, tick_wake = 1'b0;
    logic       cpu_ce, per_ce;
    logic [2:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clkpm_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slow_en(cfg_slow_en),
        .cfg_div_sel(cfg_div_sel), .wait_req(wait_req), .halt_req(halt_req),
        .osc_keep(osc_keep), .irq_wake(irq_wake), .tick_wake(tick_wake),
        .cpu_ce(cpu_ce), .per_ce(per_ce), .mode_o(mode_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_mode(input int exp, input string req);
        check(mode_o == 3'(exp), req, "mode", int'(mode_o), exp);
    endtask

    // Scoreboard: expected gaps between per_ce pulses
    int    exp_q[$];
    bit    mon_en = 1'b0;
    bit    have_last = 1'b0;
    bit    cpu_same = 1'b1;
    bit    cpu_bad = 1'b0;
    int    since = 0;
    int    exp_gap;
    string mon_tag = "";

    always @(negedge clk) begin
        if (mon_en) begin
            since++;
            if (cpu_same ? (cpu_ce !== per_ce) : (cpu_ce !== 1'b0)) cpu_bad = 1'b1;
            if (per_ce) begin
                if (have_last && exp_q.size() > 0) begin
                    exp_gap = exp_q.pop_front();
                    check(since == exp_gap && !cpu_bad, mon_tag,
                          cpu_bad ? "cpu_ce/gap" : "gap", since, exp_gap);
                end
                have_last = 1'b1;
                since = 0;
                cpu_bad = 1'b0;
            end
        end
    end

    task automatic sb_expect(input int gap, input int n, input bit same, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back(gap);
        mon_tag   = tag;
        cpu_same  = same;
        have_last = 1'b0;
        since     = 0;
        cpu_bad   = 1'b0;
        mon_en    = 1'b1;
        wait (exp_q.size() == 0);
        mon_en    = 1'b0;
    endtask

    task automatic write_cfg(input bit en, input logic [1:0] sel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slow_en = en; cfg_div_sel = sel;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req_wait();
        @(negedge clk); wait_req = 1'b1;
        @(negedge clk); wait_req = 1'b0;
    endtask

    task automatic req_halt();
        @(negedge clk); halt_req = 1'b1;
        @(negedge clk); halt_req = 1'b0;
    endtask

    task automatic wake_irq();
        @(negedge clk); irq_wake = 1'b1;
        @(negedge clk); irq_wake = 1'b0;
    endtask

    task automatic wake_tick();
        @(negedge clk); tick_wake = 1'b1;
        @(negedge clk); tick_wake = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!per_ce);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_mode(0, "R1");
        check(cpu_ce == 1'b1, "R1", "cpu_ce", int'(cpu_ce), 1);
        check(per_ce == 1'b1, "R1", "per_ce", int'(per_ce), 1);
        sb_expect(1, 4, 1'b1, "R1");

        // R2 / R3 slow mode at several ratios
        write_cfg(1'b1, 2'd0);
        @(negedge clk);
        check_mode(1, "R2");
        sb_expect(2, 4, 1'b1, "R3");
        write_cfg(1'b1, 2'd2);
        sb_expect(8, 3, 1'b1, "R2");
        write_cfg(1'b1, 2'd3);
        sb_expect(16, 2, 1'b1, "R2");
        write_cfg(1'b1, 2'd1);
        sb_expect(4, 2, 1'b1, "R3");

        // R10 select change in mid-period
        wait_pulse();
        g = 0;
        do begin
            @(negedge clk);
            g++;
            if (g == 1) begin cfg_we = 1'b1; cfg_slow_en = 1'b1; cfg_div_sel = 2'd3; end
            if (g == 2) cfg_we = 1'b0;
        end while (!per_ce);
        check(g == 4, "R10", "old period", g, 4);
        g = 0;
        do begin @(negedge clk); g++; end while (!per_ce);
        check(g == 16, "R10", "new period", g, 16);
        write_cfg(1'b1, 2'd1);
        sb_expect(4, 2, 1'b1, "R3");

        // R4 slow-wait, R9 resume to slow
        req_wait();
        check_mode(3, "R4");
        sb_expect(4, 3, 1'b0, "R4");
        wake_irq();
        check_mode(1, "R9");

        // R2 leave slow
        write_cfg(1'b0, 2'd1);
        @(negedge clk);
        check_mode(0, "R2");

        // R5 wait from run, R11 requests ignored, R9 resume to run
        req_wait();
        check_mode(2, "R5");
        check(cpu_ce == 1'b0, "R5", "cpu_ce", int'(cpu_ce), 0);
        check(per_ce == 1'b1, "R5", "per_ce", int'(per_ce), 1);
        req_wait();
        check_mode(2, "R11");
        req_halt();
        check_mode(2, "R11");
        wake_irq();
        check_mode(0, "R9");

        // R6 active-halt, R8 tick wake
        osc_keep = 1'b1;
        req_halt();
        check_mode(4, "R6");
        repeat (5) @(negedge clk);
        check(cpu_ce == 1'b0 && per_ce == 1'b0, "R6", "enables", int'({cpu_ce, per_ce}), 0);
        req_wait();
        check_mode(4, "R11");
        wake_tick();
        check_mode(0, "R8");

        // R6 full halt, R7 tick ignored, irq wakes
        osc_keep = 1'b0;
        req_halt();
        check_mode(5, "R6");
        check(cpu_ce == 1'b0 && per_ce == 1'b0, "R6", "enables", int'({cpu_ce, per_ce}), 0);
        wake_tick();
        check_mode(5, "R7");
        check(per_ce == 1'b0, "R7", "per_ce", int'(per_ce), 0);
        wake_irq();
        check_mode(0, "R7");

        // R6 halt wins over wait, R7 reset wakes
        @(negedge clk); halt_req = 1'b1; wait_req = 1'b1;
        @(negedge clk); halt_req = 1'b0; wait_req = 1'b0;
        check_mode(5, "R6");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_mode(0, "R7");

        // R8 active-halt from slow, irq returns to run
        write_cfg(1'b1, 2'd0);
        @(negedge clk);
        check_mode(1, "R2");
        osc_keep = 1'b1;
        req_halt();
        check_mode(4, "R6");
        wake_irq();
        check_mode(0, "R8");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule